// File: doc/BRIEF.md
# DDS Register Write Decoder

This block takes 16-bit command words, one for each cycle in which the write strobe is high, and sorts them into the register set that feeds a numerically controlled oscillator. That register set holds a 14-bit control word, two 28-bit frequency tuning words and two 12-bit phase offsets. The two top bits of each command name the destination. The lower 14 bits are the payload.

Frequency words are wider than one payload, so they can be loaded in two ways. A control bit chooses the way. In wide mode, two writes to the same frequency address form one word: the low half comes first and the high half second. The whole word is committed in a single cycle, so the oscillator never sees a mix of old and new halves. In narrow mode, each write replaces one half right away, and a second control bit picks which half.

A clear bit in the control word forces every frequency and phase register to zero and keeps it there for as long as the bit is set.

Top module: `dds_regfile`

## Requirements
- R1: Bits 15:14 of a command are the address: 00 = control, 01 = frequency word 0, 10 = frequency word 1, 11 = phase. A control write copies bits 13:0 into `ctrl_q` on the next clock edge.
- R2: With control bit 13 (wide mode) set, the first write to a frequency address supplies bits 13:0 and a second write to the same address supplies bits 27:14. The register then becomes {second payload, first payload}.
- R3: In wide mode, the addressed frequency output keeps its old value after the first half. It changes only in the cycle after the second half.
- R4: With control bit 13 clear, one frequency write replaces one half at once. Control bit 12 = 1 selects bits 27:14, and 0 selects bits 13:0. The other half is unchanged.
- R5: In wide mode, control bit 12 has no effect on how frequency writes are assembled.
- R6: In wide mode, a write to the other frequency address while a low half is held throws away the held half. That write becomes the first half of the new address, and the first address keeps its value.
- R7: A control write drops any held low half. The next frequency write is then treated as a first half.
- R8: A phase write uses payload bit 13 to choose phase register 1 (1) or 0 (0) and loads bits 11:0. Payload bit 12 is ignored.
- R9: While control bit 8 (clear) is set, both frequency and both phase outputs read zero one cycle after the control update, and frequency or phase writes leave them at zero.
- R10: A phase write between the two halves of a wide load does not disturb the held half.
- R11: After `rst_n` is asserted, every output is zero.

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one command per high cycle |
| wr_data | input | 16 | Command word: address in bits 15:14, payload in bits 13:0 |
| ctrl_q | output | 14 | Control register |
| freq0_q | output | 28 | Frequency tuning word 0 |
| freq1_q | output | 28 | Frequency tuning word 1 |
| phase0_q | output | 12 | Phase offset 0 |
| phase1_q | output | 12 | Phase offset 1 |

## Verification
The bench sweeps narrow-mode writes to both halves of both frequency words with payloads whose bit patterns differ. A wrong half-select or wrong target register therefore shows up as a value mismatch.

Wide-mode pairs are run with the half-select bit both cleared and set. After every first half, all outputs are compared, which separates an atomic commit from a leaking partial update.

Interrupted sequences are also covered:
- a switch to the other frequency address,
- a control write,
- a phase write between the halves.

These show which events discard the held half and which keep it. Phase sweeps toggle payload bit 12, and the clear bit is exercised both when it is set and when writes arrive while it is held.

// File: rtl/dds_regfile.sv
module dds_regfile #(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 2,
  parameter int FREQ_W    = 28,
  parameter int PHASE_W   = 12,
  parameter int WIDE_BIT  = 13,
  parameter int HALF_BIT  = 12,
  parameter int CLEAR_BIT = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [WORD_W-1:0]         wr_data,
  output logic [WORD_W-ADDR_W-1:0]  ctrl_q,
  output logic [FREQ_W-1:0]         freq0_q,
  output logic [FREQ_W-1:0]         freq1_q,
  output logic [PHASE_W-1:0]        phase0_q,
  output logic [PHASE_W-1:0]        phase1_q
);
  localparam int PAY_W    = WORD_W - ADDR_W;
  localparam int HALF_W   = FREQ_W / 2;
  localparam int PSEL_BIT = PAY_W - 1;

  logic [ADDR_W-1:0]  addr;
  logic [PAY_W-1:0]   pay;
  logic               wr_ctrl, wr_freq, wr_phase, fidx;
  logic               wide, narrow_hi, clr, commit;
  logic               pend_q, pend_idx_q;
  logic [HALF_W-1:0]  hold_q;
  logic [FREQ_W-1:0]  freq_r  [2];
  logic [PHASE_W-1:0] phase_r [2];

  assign addr      = wr_data[WORD_W-1 -: ADDR_W];
  assign pay       = wr_data[PAY_W-1:0];
  assign wr_ctrl   = wr_en && (addr == ADDR_W'(0));
  assign wr_freq   = wr_en && (addr == ADDR_W'(1) || addr == ADDR_W'(2));
  assign wr_phase  = wr_en && (addr == ADDR_W'(3));
  assign fidx      = addr[1];
  assign wide      = ctrl_q[WIDE_BIT];
  assign narrow_hi = ctrl_q[HALF_BIT];
  assign clr       = ctrl_q[CLEAR_BIT];
  assign commit    = wr_freq && wide && pend_q && (pend_idx_q == fidx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (wr_ctrl)
      ctrl_q <= pay;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_idx_q <= 1'b0;
      hold_q     <= '0;
    end else if (clr || wr_ctrl) begin
      pend_q <= 1'b0;
    end else if (wr_freq && wide) begin
      if (commit) begin
        pend_q <= 1'b0;
      end else begin
        pend_q     <= 1'b1;
        pend_idx_q <= fidx;
        hold_q     <= HALF_W'(pay);
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        freq_r[g] <= '0;
      else if (clr)
        freq_r[g] <= '0;
      else if (wr_freq && fidx == 1'(g)) begin
        if (wide) begin
          if (commit)
            freq_r[g] <= {HALF_W'(pay), hold_q};
        end else if (narrow_hi)
          freq_r[g][FREQ_W-1:HALF_W] <= HALF_W'(pay);
        else
          freq_r[g][HALF_W-1:0] <= HALF_W'(pay);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        phase_r[g] <= '0;
      else if (clr)
        phase_r[g] <= '0;
      else if (wr_phase && pay[PSEL_BIT] == 1'(g))
        phase_r[g] <= pay[PHASE_W-1:0];
    end
  end

  assign freq0_q  = freq_r[0];
  assign freq1_q  = freq_r[1];
  assign phase0_q = phase_r[0];
  assign phase1_q = phase_r[1];
endmodule

module dds_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [13:0] ctrl_q,
  input logic [27:0] freq0_q,
  input logic [27:0] freq1_q,
  input logic [11:0] phase0_q,
  input logic [11:0] phase1_q,
  input logic        pend_q
);
  // R1
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[15:14] == 2'b00) |=> ctrl_q == $past(wr_data[13:0]));

  // R3
  atomic_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(freq0_q) && $past(ctrl_q[13]) && !$past(ctrl_q[8])) |-> $past(pend_q));

  // R4
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[15:14] == 2'b01 && !ctrl_q[13] && ctrl_q[12] && !ctrl_q[8])
    |=> freq0_q[27:14] == $past(wr_data[13:0]) && freq0_q[13:0] == $past(freq0_q[13:0]));

  // R7
  ctrl_drops_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[15:14] == 2'b00) |=> !pend_q);

  // R8
  phase0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[15:14] == 2'b11 && !wr_data[13] && !ctrl_q[8])
    |=> phase0_q == $past(wr_data[11:0]));

  // R9
  clear_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[8] |=> (freq0_q == 28'd0 && freq1_q == 28'd0 && phase0_q == 12'd0 && phase1_q == 12'd0));
endmodule

bind dds_regfile dds_regfile_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(ctrl_q),
  .freq0_q(freq0_q), .freq1_q(freq1_q), .phase0_q(phase0_q), .phase1_q(phase1_q),
  .pend_q(pend_q)
);

// File: tb/dds_regfile_tb.sv
module dds_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [13:0] ctrl_q;
  logic [27:0] freq0_q, freq1_q;
  logic [11:0] phase0_q, phase1_q;

  int n_cmp = 0;
  int n_bad = 0;

  logic [13:0] m_ctrl = '0;
  logic [27:0] m_f [2] = '{28'd0, 28'd0};
  logic [11:0] m_p [2] = '{12'd0, 12'd0};
  logic        m_pend = 1'b0;
  logic        m_pidx = 1'b0;
  logic [13:0] m_hold = '0;

  always #2 clk = ~clk;

  dds_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(ctrl_q),
    .freq0_q(freq0_q), .freq1_q(freq1_q), .phase0_q(phase0_q), .phase1_q(phase1_q)
  );

  task automatic cmp(input string tag, input logic [27:0] act, input logic [27:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp({tag, " ctrl"},   28'(ctrl_q),   28'(m_ctrl));
    cmp({tag, " freq0"},  freq0_q,       m_f[0]);
    cmp({tag, " freq1"},  freq1_q,       m_f[1]);
    cmp({tag, " phase0"}, 28'(phase0_q), 28'(m_p[0]));
    cmp({tag, " phase1"}, 28'(phase1_q), 28'(m_p[1]));
  endtask

  task automatic model(input logic [1:0] a, input logic [13:0] d);
    logic fi;
    fi = a[1];
    if (a == 2'b00) begin
      m_ctrl = d;
      m_pend = 1'b0;
    end else if (m_ctrl[8]) begin
      m_pend = 1'b0;
    end else if (a == 2'b11) begin
      m_p[d[13]] = d[11:0];
    end else if (m_ctrl[13]) begin
      if (m_pend && m_pidx == fi) begin
        m_f[fi] = {d, m_hold};
        m_pend = 1'b0;
      end else begin
        m_pend = 1'b1;
        m_pidx = fi;
        m_hold = d;
      end
    end else if (m_ctrl[12]) begin
      m_f[fi][27:14] = d;
    end else begin
      m_f[fi][13:0] = d;
    end
    if (m_ctrl[8]) begin
      m_f = '{28'd0, 28'd0};
      m_p = '{12'd0, 12'd0};
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [13:0] d, input string tag);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = {a, d};
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    model(a, d);
    check_all(tag);
  endtask

  initial begin
    #400000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R11 reset");

    // R4 narrow mode low and high halves on both words
    wr(2'b00, 14'h0000, "R1 ctrl narrow low");
    for (int i = 0; i < 6; i++) begin
      wr(2'b01, 14'(14'h0155 * (i + 1) ^ (i << 9)), "R4 f0 low");
      wr(2'b10, 14'(14'h2AA3 ^ (i * 14'h0731)), "R4 f1 low");
    end
    wr(2'b00, 14'h1000, "R1 ctrl narrow high");
    for (int i = 0; i < 6; i++) begin
      wr(2'b01, 14'(14'h3F01 - i * 14'h0213), "R4 f0 high");
      wr(2'b10, 14'(14'h0C3C + i * 14'h1111), "R4 f1 high");
    end

    // R2 R3 R5 wide mode pairs with half-select clear and set
    for (int h = 0; h < 2; h++) begin
      wr(2'b00, 14'(14'h2000 | (h << 12)), "R1 ctrl wide");
      for (int i = 0; i < 5; i++) begin
        for (int a = 1; a <= 2; a++) begin
          wr(2'(a), 14'(14'h1234 + i * 14'h0987 + a), "R3 first half no change");
          wr(2'(a), 14'(14'h3ABC - i * 14'h0456 - h), "R2 R5 second half commit");
        end
      end
    end

    // R6 switching address discards held half
    wr(2'b01, 14'h0AAA, "R3 f0 first");
    wr(2'b10, 14'h1555, "R6 f1 fresh first");
    wr(2'b10, 14'h2F0F, "R6 f1 commit");
    wr(2'b01, 14'h3333, "R6 f0 first after discard");
    wr(2'b01, 14'h0101, "R6 f0 commit");

    // R7 control write drops pending half
    wr(2'b01, 14'h1111, "R3 f0 first before ctrl");
    wr(2'b00, 14'h2000, "R7 ctrl write");
    wr(2'b01, 14'h2222, "R7 f0 treated as first");
    wr(2'b01, 14'h3CCC, "R7 f0 commit");

    // R10 phase write between halves keeps pending
    wr(2'b10, 14'h0F0F, "R3 f1 first before phase");
    wr(2'b11, 14'h2ABC, "R10 phase between halves");
    wr(2'b10, 14'h1E1E, "R10 f1 commit");

    // R8 phase sweep, bit 12 toggled
    for (int i = 0; i < 8; i++)
      wr(2'b11, 14'(((i & 1) << 13) | ((i & 2) << 11) | (12'h5A3 + i * 12'h1F1)), "R8 phase");

    // R9 clear bit
    wr(2'b00, 14'h0100, "R9 clear set");
    wr(2'b01, 14'h1FFF, "R9 freq write during clear");
    wr(2'b11, 14'h2777, "R9 phase write during clear");
    wr(2'b00, 14'h0000, "R9 clear released");
    wr(2'b01, 14'h0ABC, "R9 write after clear");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule